// File: doc/BRIEF.md
# Chained Descriptor DMA Source Channel

This block is one source channel of a DMA controller that follows a chain of descriptors held in memory. Software loads a descriptor address, sets the start bit in the control register, and the channel then reads a 128-bit descriptor tag, decodes it, reads the payload quadwords it describes and hands them one by one to a valid/ready output port. When a packet is complete, the channel works out where the next descriptor lives and fetches it, until a descriptor ends the chain, a tagged interrupt stops it, or the memory reports an error.

The lower 64 bits of each tag quadword carry the tag: bits 15:0 hold the quadword count, bits 27:26 a priority-control field (stored but not acted on), bits 30:28 the tag kind, and bit 31 an interrupt request. Bits 63:32 hold the target byte address. Address bit 31 selects scratchpad memory and passes through unchanged to the memory port. The kind decides both where the payload comes from and where the next tag is found. A two-entry address stack supports subroutine-style chains built from call and return tags.

Top module: `qw_chain_dma`

## Requirements
- R1: After reset, every register reads zero, `busy`, `mem_req`, `out_valid`, `irq_flag` and `berr_flag` are low.
- R2: While idle, a write on the register port updates the selected register, as follows. Select 0 is control, 1 is memory address, 2 is tag address, 3 is count, 4 is stack entry 0 and 5 is stack entry 1. Address registers read back with bits 3:0 zero. While `busy`, writes are ignored.
- R3: Writing control with bit 8 (start) set starts the channel. The channel first reads a tag at the tag address. Each good tag read loads the count from tag bits 15:0 and control bits 31:16 from tag bits 31:16. Every memory address issued has bits 3:0 zero.
- R4: Kind 0 (refe) takes its payload at the tag address field, with bits 3:0 cleared, and ends the chain with the tag address unchanged. Kinds 3 and 4 (ref, refs) take the payload at the same place and move the tag address on by 16.
- R5: Kinds 1 (cnt), 2 (next) and 7 (end) take their payload right after the tag. cnt sets the tag address just past the payload. next sets the tag address to the tag address field. end stops the chain with the tag address just past the payload.
- R6: Kind 5 (call) takes its payload right after the tag. It pushes the address just past the payload into stack entry N, where N is the stack pointer in control bits 5:4. It then increments the pointer and jumps to the tag address field. Kind 6 (ret) takes its payload right after the tag, decrements the pointer and continues at the entry it then names.
- R7: A call with the pointer at 2, or a ret with the pointer at 0, behaves as end. The pointer and the stack entries are left unchanged.
- R8: Exactly the counted payload quadwords appear on `out_data` in ascending address order. A count of zero sends none. `out_valid` and `out_data` hold until `out_ready` is taken. The memory address register advances by 16 per quadword sent.
- R9: When control bit 7 (tag interrupt enable) is set and the current tag has bit 31 set, the channel stops once that packet is sent and raises `irq_flag`. With bit 7 clear, the tag bit has no effect.
- R10: An error response on any read sets `berr_flag` and stops the channel. On a tag read, the count and control bits 31:16 are left unchanged.
- R11: Whenever the channel stops, control bit 8 reads zero and `busy` falls. Starting again clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 32 | Read byte address, quadword aligned |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 128 | Read response data |
| mem_rerr | input | 1 | Read response carries an error |
| out_valid | output | 1 | Payload quadword valid |
| out_ready | input | 1 | Sink accepts the payload quadword |
| out_data | output | 128 | Payload quadword |
| busy | output | 1 | Channel running |
| irq_flag | output | 1 | Chain stopped on a tag interrupt |
| berr_flag | output | 1 | Chain stopped on a read error |

## Verification
The assertions check on every cycle that issued addresses are aligned, that a stalled payload quadword holds steady, and that the count drops by one per accepted quadword. They also check that the stack is never pushed when full or popped when empty, that a read error stops the channel, and that every stop clears the start bit. Only the bench scenarios can show that each tag kind picks the right payload and next-tag address. The same holds for call/return nesting, stack overflow and underflow falling back to end, interrupt-enable gating, and writes being dropped while busy. The bench sweeps every non-stack kind over counts 0 to 3, with steady and stalling sinks.

// File: rtl/qcd_pkg.sv
package qcd_pkg;

  typedef enum logic [2:0] {
    K_REFE = 3'd0, K_CNT = 3'd1, K_NEXT = 3'd2, K_REF = 3'd3,
    K_REFS = 3'd4, K_CALL = 3'd5, K_RET = 3'd6, K_END = 3'd7
  } tag_kind_e;

  typedef struct packed {
    logic [31:0] target;
    logic        irq;
    tag_kind_e   kind;
    logic [1:0]  prio;
    logic [9:0]  spare;
    logic [15:0] count;
  } tag_t;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_MADR = 3'd1;
  localparam logic [2:0] SEL_TADR = 3'd2;
  localparam logic [2:0] SEL_QWC  = 3'd3;
  localparam logic [2:0] SEL_STK0 = 3'd4;

  localparam int CB_START = 8;
  localparam int CB_TIE   = 7;
  localparam int CB_SP    = 4;

endpackage

// File: rtl/qcd_decode.sv
module qcd_decode
  import qcd_pkg::*;
#(
  parameter int AW      = 32,
  parameter int QB      = 16,
  parameter int STACK_D = 2
) (
  input  tag_t          tag,
  input  logic [AW-1:0] tadr,
  input  logic [1:0]    sp,
  input  logic [AW-1:0] pop_addr,
  output logic [AW-1:0] madr_nx,
  output logic [AW-1:0] tadr_nx,
  output logic [AW-1:0] ret_addr,
  output logic [15:0]   ctrl_hi,
  output logic          push,
  output logic          pop,
  output logic          stop
);
  localparam int QS = $clog2(QB);
  localparam logic [AW-1:0] ALIGN = ~AW'(QB - 1);

  logic [AW-1:0] after_tag, target_al;

  assign after_tag = tadr + AW'(QB);
  assign ret_addr  = after_tag + (AW'(tag.count) << QS);
  assign target_al = AW'(tag.target) & ALIGN;
  assign ctrl_hi   = {tag.irq, tag.kind, tag.prio, tag.spare};

  always_comb begin
    madr_nx = after_tag;
    tadr_nx = ret_addr;
    push    = 1'b0;
    pop     = 1'b0;
    stop    = 1'b0;
    case (tag.kind)
      K_REFE: begin
        madr_nx = target_al;
        tadr_nx = tadr;
        stop    = 1'b1;
      end
      K_CNT:  ;
      K_NEXT: tadr_nx = target_al;
      K_REF, K_REFS: begin
        madr_nx = target_al;
        tadr_nx = after_tag;
      end
      K_CALL: begin
        if (32'(sp) < STACK_D) begin
          push    = 1'b1;
          tadr_nx = target_al;
        end else begin
          stop = 1'b1;
        end
      end
      K_RET: begin
        if (sp != 2'd0) begin
          pop     = 1'b1;
          tadr_nx = pop_addr;
        end else begin
          stop = 1'b1;
        end
      end
      default: stop = 1'b1;
    endcase
  end
endmodule

// File: rtl/qcd_stack.sv
module qcd_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst_q_n,
  input  logic                      push,
  input  logic                      pop,
  input  logic [1:0]                sp,
  input  logic [AW-1:0]             push_data,
  input  logic [DEPTH-1:0]          sw_we,
  input  logic [AW-1:0]             sw_wdata,
  output logic [DEPTH-1:0][AW-1:0]  entries,
  output logic [AW-1:0]             pop_data
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic load_push;
    assign load_push = push && (32'(sp) == g);
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)           entries[g] <= '0;
      else if (sw_we[g])      entries[g] <= sw_wdata;
      else if (load_push)     entries[g] <= push_data;
    end
  end

  always_comb begin
    pop_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (32'(sp) == i + 1) pop_data = entries[i];
  end

  // R6 / R7: the decoder must never push a full stack or pop an empty one
  p_push_room_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    push |-> (32'(sp) < DEPTH));
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    pop |-> (sp != 2'd0));
  p_one_op_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(push && pop));
endmodule

// File: rtl/qw_chain_dma.sv
module qw_chain_dma
  import qcd_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 128,
  parameter int STACK_D = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rerr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          busy,
  output logic          irq_flag,
  output logic          berr_flag
);
  localparam int QB = DW / 8;
  localparam logic [AW-1:0] ALIGN = ~AW'(QB - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_TAG, ST_DATA, ST_OUT} st_e;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  st_e           st_q, st_n;
  logic [31:0]   ctrl_q, ctrl_n;
  logic [AW-1:0] madr_q, madr_n, tadr_q, tadr_n;
  logic [15:0]   qwc_q, qwc_n;
  logic          stop_q, stop_n, ireq_q, ireq_n;
  logic          irq_q, irq_n, berr_q, berr_n;
  logic [DW-1:0] buf_q, buf_n;
  logic          buf_en;

  logic [AW-1:0] dec_madr, dec_tadr, ret_addr, pop_data;
  logic [15:0]   dec_hi;
  logic          dec_push, dec_pop, dec_stop, push, pop;
  logic [STACK_D-1:0]         stk_we;
  logic [STACK_D-1:0][AW-1:0] stk;
  tag_t          tag;
  logic          idle_wr, tag_ok;

  assign tag     = tag_t'(mem_rdata[63:0]);
  assign idle_wr = (st_q == ST_IDLE) && reg_we;
  assign tag_ok  = (st_q == ST_TAG) && mem_rvalid && !mem_rerr;
  assign push    = tag_ok && dec_push;
  assign pop     = tag_ok && dec_pop;

  qcd_decode #(.AW(AW), .QB(QB), .STACK_D(STACK_D)) i_decode (
    .tag(tag), .tadr(tadr_q), .sp(ctrl_q[CB_SP+:2]), .pop_addr(pop_data),
    .madr_nx(dec_madr), .tadr_nx(dec_tadr), .ret_addr(ret_addr),
    .ctrl_hi(dec_hi), .push(dec_push), .pop(dec_pop), .stop(dec_stop)
  );

  for (genvar g = 0; g < STACK_D; g++) begin : g_stk_we
    assign stk_we[g] = idle_wr && (reg_sel == SEL_STK0 + 3'(g));
  end

  qcd_stack #(.AW(AW), .DEPTH(STACK_D)) i_stack (
    .clk(clk), .rst_q_n(rst_q_n), .push(push), .pop(pop),
    .sp(ctrl_q[CB_SP+:2]), .push_data(ret_addr), .sw_we(stk_we),
    .sw_wdata(AW'(reg_wdata) & ALIGN), .entries(stk), .pop_data(pop_data)
  );

  // next-state logic
  always_comb begin
    st_n   = st_q;
    ctrl_n = ctrl_q;
    madr_n = madr_q;
    tadr_n = tadr_q;
    qwc_n  = qwc_q;
    stop_n = stop_q;
    ireq_n = ireq_q;
    irq_n  = irq_q;
    berr_n = berr_q;
    buf_en = 1'b0;
    buf_n  = mem_rdata;
    case (st_q)
      ST_IDLE: begin
        if (reg_we) begin
          case (reg_sel)
            SEL_CTRL: begin
              ctrl_n = reg_wdata;
              if (reg_wdata[CB_START]) begin
                st_n   = ST_TAG;
                irq_n  = 1'b0;
                berr_n = 1'b0;
              end
            end
            SEL_MADR: madr_n = AW'(reg_wdata) & ALIGN;
            SEL_TADR: tadr_n = AW'(reg_wdata) & ALIGN;
            SEL_QWC:  qwc_n  = reg_wdata[15:0];
            default: ;
          endcase
        end
      end
      ST_TAG: begin
        if (mem_rvalid) begin
          if (mem_rerr) begin
            berr_n           = 1'b1;
            ctrl_n[CB_START] = 1'b0;
            st_n             = ST_IDLE;
          end else begin
            qwc_n          = tag.count;
            ctrl_n[31:16]  = dec_hi;
            madr_n         = dec_madr;
            tadr_n         = dec_tadr;
            stop_n         = dec_stop;
            ireq_n         = ctrl_q[CB_TIE] && tag.irq;
            if (dec_push) ctrl_n[CB_SP+:2] = ctrl_q[CB_SP+:2] + 2'd1;
            if (dec_pop)  ctrl_n[CB_SP+:2] = ctrl_q[CB_SP+:2] - 2'd1;
            if (tag.count != 16'd0) begin
              st_n = ST_DATA;
            end else if (dec_stop || ireq_n) begin
              st_n             = ST_IDLE;
              ctrl_n[CB_START] = 1'b0;
              irq_n            = ireq_n;
            end
          end
        end
      end
      ST_DATA: begin
        if (mem_rvalid) begin
          if (mem_rerr) begin
            berr_n           = 1'b1;
            ctrl_n[CB_START] = 1'b0;
            st_n             = ST_IDLE;
          end else begin
            buf_en = 1'b1;
            st_n   = ST_OUT;
          end
        end
      end
      default: begin
        if (out_ready) begin
          madr_n = madr_q + AW'(QB);
          qwc_n  = qwc_q - 16'd1;
          if (qwc_q != 16'd1) begin
            st_n = ST_DATA;
          end else if (stop_q || ireq_q) begin
            st_n             = ST_IDLE;
            ctrl_n[CB_START] = 1'b0;
            irq_n            = ireq_q;
          end else begin
            st_n = ST_TAG;
          end
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q   <= ST_IDLE;
      ctrl_q <= '0;
      madr_q <= '0;
      tadr_q <= '0;
      qwc_q  <= '0;
      stop_q <= 1'b0;
      ireq_q <= 1'b0;
      irq_q  <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ctrl_q <= ctrl_n;
      madr_q <= madr_n;
      tadr_q <= tadr_n;
      qwc_q  <= qwc_n;
      stop_q <= stop_n;
      ireq_q <= ireq_n;
      irq_q  <= irq_n;
      berr_q <= berr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    buf_q <= '0;
    else if (buf_en) buf_q <= buf_n;
  end

  assign mem_req   = (st_q == ST_TAG) || (st_q == ST_DATA);
  assign mem_addr  = (st_q == ST_TAG) ? tadr_q : madr_q;
  assign out_valid = (st_q == ST_OUT);
  assign out_data  = buf_q;
  assign busy      = (st_q != ST_IDLE);
  assign irq_flag  = irq_q;
  assign berr_flag = berr_q;

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_MADR: reg_rdata = 32'(madr_q);
      SEL_TADR: reg_rdata = 32'(tadr_q);
      SEL_QWC:  reg_rdata = {16'd0, qwc_q};
      default: begin
        reg_rdata = '0;
        for (int i = 0; i < STACK_D; i++)
          if (reg_sel == SEL_STK0 + 3'(i)) reg_rdata = 32'(stk[i]);
      end
    endcase
  end

  // R3: only aligned addresses leave the channel
  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_req |-> (mem_addr[3:0] == 4'd0));
  // R8: a stalled quadword holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R8: one count per accepted quadword
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && out_ready) |=> (qwc_q == $past(qwc_q) - 16'd1));
  // R10: a read error stops the channel
  p_berr_stop_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_req && mem_rvalid && mem_rerr) |=> (berr_flag && !busy));
  // R11: every stop clears the start bit
  p_start_clear_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(busy) |-> !ctrl_q[CB_START]);
  // R9: the interrupt flag only rises as the channel stops
  p_irq_stop_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(irq_flag) |-> !busy);
endmodule

// File: tb/test_qw_chain_dma.sv
module test_qw_chain_dma;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_sel = 3'd0;
  logic [31:0]  reg_wdata = 32'd0;
  logic [31:0]  reg_rdata;
  logic         mem_req, mem_rvalid, mem_rerr;
  logic [31:0]  mem_addr;
  logic [127:0] mem_rdata, out_data;
  logic         out_valid, out_ready = 1'b1;
  logic         busy, irq_flag, berr_flag;

  int nchk = 0, nfail = 0, cyc = 0, ready_mode = 0, ngot = 0, nexp = 0;
  logic [127:0] mem [0:63];
  logic [127:0] got [0:15];
  int           exp_idx [0:15];

  always #4 clk = ~clk;

  assign mem_rvalid = mem_req;
  assign mem_rerr   = mem_addr[11];
  assign mem_rdata  = mem[mem_addr[9:4]];

  qw_chain_dma i_qw_chain_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_rerr(mem_rerr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .busy(busy), .irq_flag(irq_flag), .berr_flag(berr_flag)
  );

  // drive ready and record the handshakes that the next edge will take
  always @(negedge clk) begin
    cyc = cyc + 1;
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
    if (out_valid && out_ready && ngot < 16) begin
      got[ngot] = out_data;
      ngot = ngot + 1;
    end
  end

  function automatic logic [127:0] pay(input int i);
    return {32'hA5A5_0000 + 32'(i), 32'(i * 7), ~32'(i), 32'hC0DE_0000 + 32'(i)};
  endfunction

  function automatic logic [127:0] mk_tag(input int kind, input int q,
                                          input logic [31:0] a, input bit irq);
    return {64'h5A5A_0000_FFFF_1234, a, irq, 3'(kind), 2'b11, 10'd0, 16'(q)};
  endfunction

  function automatic logic [15:0] hi(input int kind, input bit irq);
    return {irq, 3'(kind), 2'b11, 10'd0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic fill();
    for (int i = 0; i < 64; i++) mem[i] = pay(i);
  endtask

  task automatic start(input logic [31:0] tadr, input int sp, input bit tie);
    ngot = 0;
    wreg(3'd2, tadr);
    wreg(3'd0, 32'h0000_0100 | (32'(tie) << 7) | (32'(sp) << 4));
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    chk("R11 channel stops", {31'd0, busy}, 32'd0);
  endtask

  task automatic chk_out(input string req);
    chk({req, " output count"}, 32'(ngot), 32'(nexp));
    for (int i = 0; i < nexp && i < ngot; i++)
      if (got[i] !== pay(exp_idx[i])) begin
        nchk++; nfail++;
        $display("FAIL %s beat %0d actual=%h expected=%h", req, i, got[i], pay(exp_idx[i]));
      end
  endtask

  task automatic chk_end(input string req, input logic [31:0] em, input logic [31:0] et,
                         input logic [15:0] eh);
    logic [31:0] v;
    rd(3'd1, v); chk({req, " madr"}, v, em);
    rd(3'd2, v); chk({req, " tadr"}, v, et);
    rd(3'd3, v); chk({req, " count drained R8"}, v, 32'd0);
    rd(3'd0, v);
    chk({req, " ctrl upper R3"}, {16'd0, v[31:16]}, {16'd0, eh});
    chk({req, " start cleared R11"}, {31'd0, v[8]}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int kinds [6] = '{0, 1, 2, 3, 4, 7};
    fill();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v); chk("R1 register reset", v, 32'd0);
    end
    chk("R1 outputs idle", {27'd0, busy, mem_req, out_valid, irq_flag, berr_flag}, 32'd0);

    // R2 register writes while idle
    wreg(3'd1, 32'h1234_5678); rd(3'd1, v); chk("R2 madr aligned", v, 32'h1234_5670);
    wreg(3'd3, 32'h0000_FFFF); rd(3'd3, v); chk("R2 count", v, 32'h0000_FFFF);
    wreg(3'd4, 32'h0000_0ABF); rd(3'd4, v); chk("R2 stack entry 0", v, 32'h0000_0AB0);
    wreg(3'd5, 32'h8000_0101); rd(3'd5, v); chk("R2 stack entry 1", v, 32'h8000_0100);

    // R4 R5 R8 sweep: kinds without the stack over counts 0..3
    for (int k = 0; k < 6; k++) begin
      for (int q = 0; q < 4; q++) begin
        int kd = kinds[k];
        logic [31:0] em, et;
        logic [15:0] eh;
        fill();
        ready_mode = q % 2;
        nexp = q;
        eh = hi(7, 0);
        case (kd)
          0: begin
            mem[16] = mk_tag(0, q, 32'h0000_0207, 0);
            for (int i = 0; i < q; i++) exp_idx[i] = 32 + i;
            em = 32'h200 + 32'(16 * q); et = 32'h100; eh = hi(0, 0);
          end
          1: begin
            mem[16] = mk_tag(1, q, 32'h0, 0);
            mem[17 + q] = mk_tag(7, 0, 32'h0, 0);
            for (int i = 0; i < q; i++) exp_idx[i] = 17 + i;
            em = 32'h120 + 32'(16 * q); et = em;
          end
          2: begin
            mem[16] = mk_tag(2, q, 32'h0000_0300, 0);
            mem[48] = mk_tag(7, 0, 32'h0, 0);
            for (int i = 0; i < q; i++) exp_idx[i] = 17 + i;
            em = 32'h310; et = 32'h310;
          end
          3, 4: begin
            mem[16] = mk_tag(kd, q, 32'h0000_0207, 0);
            mem[17] = mk_tag(7, 0, 32'h0, 0);
            for (int i = 0; i < q; i++) exp_idx[i] = 32 + i;
            em = 32'h120; et = 32'h120;
          end
          default: begin
            mem[16] = mk_tag(7, q, 32'h0, 0);
            for (int i = 0; i < q; i++) exp_idx[i] = 17 + i;
            em = 32'h110 + 32'(16 * q); et = em; eh = hi(7, 0);
          end
        endcase
        start(32'h100, 0, 0);
        wait_idle();
        chk_out((kd == 0 || kd == 3 || kd == 4) ? "R4 payload" : "R5 payload");
        chk_end((kd == 0 || kd == 3 || kd == 4) ? "R4 chain" : "R5 chain", em, et, eh);
      end
    end
    ready_mode = 1;

    // R6 call then ret
    fill();
    mem[16] = mk_tag(5, 1, 32'h300, 0);
    mem[48] = mk_tag(6, 2, 32'h0, 0);
    mem[18] = mk_tag(7, 0, 32'h0, 0);
    nexp = 3; exp_idx[0] = 17; exp_idx[1] = 49; exp_idx[2] = 50;
    start(32'h100, 0, 0);
    wait_idle();
    chk_out("R6 call/ret");
    chk_end("R6 call/ret", 32'h130, 32'h130, hi(7, 0));
    rd(3'd4, v); chk("R6 pushed return", v, 32'h120);
    rd(3'd0, v); chk("R6 pointer back to 0", {30'd0, v[5:4]}, 32'd0);

    // R6 nested calls fill both entries
    fill();
    mem[16] = mk_tag(5, 0, 32'h300, 0);
    mem[48] = mk_tag(5, 0, 32'h380, 0);
    mem[56] = mk_tag(6, 1, 32'h0, 0);
    mem[49] = mk_tag(6, 0, 32'h0, 0);
    mem[17] = mk_tag(7, 1, 32'h0, 0);
    nexp = 2; exp_idx[0] = 57; exp_idx[1] = 18;
    start(32'h100, 0, 0);
    wait_idle();
    chk_out("R6 nested");
    chk_end("R6 nested", 32'h130, 32'h130, hi(7, 0));
    rd(3'd4, v); chk("R6 entry 0", v, 32'h110);
    rd(3'd5, v); chk("R6 entry 1", v, 32'h310);

    // R7 call on a full stack behaves as end
    fill();
    wreg(3'd4, 32'h0); wreg(3'd5, 32'h0);
    mem[16] = mk_tag(5, 1, 32'h300, 0);
    nexp = 1; exp_idx[0] = 17;
    start(32'h100, 2, 0);
    wait_idle();
    chk_out("R7 overflow");
    chk_end("R7 overflow", 32'h120, 32'h120, hi(5, 0));
    rd(3'd0, v); chk("R7 pointer kept", {30'd0, v[5:4]}, 32'd2);
    rd(3'd5, v); chk("R7 entry untouched", v, 32'h0);

    // R7 ret on an empty stack behaves as end
    fill();
    mem[16] = mk_tag(6, 1, 32'h300, 0);
    nexp = 1; exp_idx[0] = 17;
    start(32'h100, 0, 0);
    wait_idle();
    chk_out("R7 underflow");
    chk_end("R7 underflow", 32'h120, 32'h120, hi(6, 0));

    // R9 tag interrupt with enable set stops after the packet
    fill();
    mem[16] = mk_tag(1, 1, 32'h0, 1);
    mem[18] = mk_tag(7, 0, 32'h0, 0);
    nexp = 1; exp_idx[0] = 17;
    start(32'h100, 0, 1);
    wait_idle();
    chk_out("R9 enabled");
    chk_end("R9 enabled", 32'h120, 32'h120, hi(1, 1));
    chk("R9 irq flag raised", {31'd0, irq_flag}, 32'd1);

    // R9 enable clear: tag bit ignored, chain continues
    start(32'h100, 0, 0);
    chk("R11 start clears irq flag", {31'd0, irq_flag}, 32'd0);
    wait_idle();
    chk_out("R9 disabled");
    chk_end("R9 disabled", 32'h130, 32'h130, hi(7, 0));
    chk("R9 no irq flag", {31'd0, irq_flag}, 32'd0);

    // R10 error on a tag read
    wreg(3'd3, 32'd5);
    ngot = 0; nexp = 0;
    wreg(3'd2, 32'h800);
    wreg(3'd0, 32'h1234_0100);
    wait_idle();
    chk_out("R10 tag error");
    chk("R10 berr flag", {31'd0, berr_flag}, 32'd1);
    rd(3'd3, v); chk("R10 count kept", v, 32'd5);
    rd(3'd0, v); chk("R10 ctrl upper kept", {16'd0, v[31:16]}, 32'h1234);
    chk("R10 start cleared", {31'd0, v[8]}, 32'd0);

    // R10 error on a payload read
    fill();
    mem[16] = mk_tag(3, 2, 32'h840, 0);
    nexp = 0;
    start(32'h100, 0, 0);
    wait_idle();
    chk_out("R10 data error");
    chk("R10 berr flag on data", {31'd0, berr_flag}, 32'd1);
    rd(3'd3, v); chk("R10 count loaded before data", v, 32'd2);

    // R2 writes ignored while busy
    fill();
    mem[16] = mk_tag(1, 2, 32'h0, 0);
    mem[19] = mk_tag(7, 0, 32'h0, 0);
    ready_mode = 2;
    start(32'h100, 0, 0);
    chk("R11 start clears berr flag", {31'd0, berr_flag}, 32'd0);
    repeat (4) @(negedge clk);
    wreg(3'd1, 32'h0000_ABC0);
    wreg(3'd2, 32'h0);
    rd(3'd1, v); chk("R2 madr write ignored while busy", v, 32'h110);
    rd(3'd2, v); chk("R2 tadr write ignored while busy", v, 32'h130);
    chk("R8 stalled quadword offered", {31'd0, out_valid}, 32'd1);
    ready_mode = 0;
    nexp = 2; exp_idx[0] = 17; exp_idx[1] = 18;
    wait_idle();
    chk_out("R8 after stall");
    chk_end("R2 busy case", 32'h140, 32'h140, hi(7, 0));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule